// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This block turns a 64-bit binary floating-point operand into a signed or unsigned integer of 32 or 64 bits, on a 64-bit integer datapath. It splits the operand into sign, exponent and significand, shifts the significand by the exponent to separate the integer part from the fraction, rounds in the selected mode, and then either negates the rounded magnitude or replaces it with a saturation value when it does not fit. The result and an invalid flag are registered, so they appear one clock after the operand is presented.

A modular mode gives a signed 32-bit result that wraps instead of saturating. It keeps the low 32 bits of the exact rounded integer, sign-extends them to 64 bits, and gives zero for infinities and NaNs. Every 32-bit result is sign-extended from bit 31, unsigned results included, so a 32-bit value always sits in the 64-bit result in one canonical form.

Top module: `f2i_conv`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` becomes 0 and `invalid_o` becomes 0.
- R2: The result and flag for the inputs present at a rising edge appear right after that edge and hold until the next edge.
- R3: `rm_i` picks the rounding: 0 is nearest with ties to even, 1 is toward zero, 2 is toward minus infinity, 3 is toward plus infinity, and 4 is nearest with ties away from zero. Codes 5 to 7 round toward zero.
- R4: When the operand is invalid and negative (minus infinity or below the range), the result is -2^63 for signed 64-bit and -2^31 for signed 32-bit (sign-extended to 64 bits). It is 0 for both unsigned widths.
- R5: When the operand is invalid and positive (plus infinity, above the range, or any NaN whatever its sign bit), the result is 2^63-1 for signed 64-bit, 2^31-1 for signed 32-bit and 2^64-1 for unsigned 64-bit. For unsigned 32-bit it is 2^32-1 sign-extended, which is all ones.
- R6: `invalid_o` is 1 for a NaN (exponent field all ones with a non-zero fraction), for an infinity (exponent field all ones with a zero fraction), and for a rounded value outside the destination range.
- R7: When `wide_i` is 0 (32-bit destination), bits 63:32 of the result equal bit 31, for signed and for unsigned conversions.
- R8: When `modular_i` is 1, the result is the low 32 bits of the rounded integer, two's-complemented when the operand is negative, and sign-extended to 64 bits. `invalid_o` reports whether that integer is outside the signed 32-bit range. `signed_i` and `wide_i` are ignored in this mode.
- R9: When `modular_i` is 1, the result is 0 for an infinity, for a NaN, and for an unbiased exponent above 84. `invalid_o` is 1 in all three cases.
- R10: For a magnitude below 1, a signed conversion of a negative operand that rounds away from zero gives -1. A positive operand gives the rounding increment, 0 or 1.
- R11: For an unsigned destination, any negative operand gives 0. The conversion is valid when the value rounds to zero and invalid when it rounds to -1 or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 64 | Floating-point operand: sign bit 63, exponent bits 62:52, fraction bits 51:0 |
| rm_i | input | 3 | Rounding-mode code |
| signed_i | input | 1 | 1 for a signed destination |
| wide_i | input | 1 | 1 for a 64-bit destination, 0 for 32-bit |
| modular_i | input | 1 | 1 selects wrap-around 32-bit conversion |
| res_o | output | 64 | Registered integer result |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The bench goes after the range edges: exact powers of two at each limit, where an off-by-one compare would saturate -2^63 or -2^31 wrongly, or would let 2^31 through as a signed 32-bit value. It tests NaNs with the sign bit set, which a design that trusts the sign bit would saturate the wrong way, and unsigned 32-bit results, which a design that zero-extends would get wrong in the upper half. Subnormals under the directed modes, and halves under every mode, expose a wrong guard or sticky bit or a tie rule swapped between modes. Modular operands with exponents of 83 and 85 catch an alignment window that is too narrow or a missing zero override.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_TO_ZERO   = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int EXPW  = 11,
  parameter int FRACW = 52,
  localparam int OPW  = EXPW + FRACW + 1,
  localparam int UEW  = EXPW + 2,
  localparam int BIAS = (1 << (EXPW - 1)) - 1
) (
  input  logic [OPW-1:0]        op_i,
  output logic                  sign_o,
  output logic                  nan_o,
  output logic                  inf_o,
  output logic [FRACW:0]        sig_o,
  output logic signed [UEW-1:0] uexp_o
);
  logic [EXPW-1:0]  efield;
  logic [FRACW-1:0] ffield;
  logic             emax, ezero;

  assign efield = op_i[OPW-2 -: EXPW];
  assign ffield = op_i[FRACW-1:0];
  assign emax   = &efield;
  assign ezero  = ~|efield;

  assign sign_o = op_i[OPW-1];
  assign nan_o  = emax & (|ffield);
  assign inf_o  = emax & ~(|ffield);
  assign sig_o  = {~ezero, ffield};
  assign uexp_o = $signed({2'b00, efield}) - $signed(UEW'(BIAS));
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int EXPW  = 11,
  parameter int FRACW = 52,
  parameter int NARW  = 32,
  localparam int UEW    = EXPW + 2,
  localparam int MODLIM = NARW + FRACW,
  localparam int INTW   = MODLIM + 2,
  localparam int PW     = INTW + FRACW + 1,
  localparam int SHW    = $clog2(MODLIM + 2)
) (
  input  logic [FRACW:0]        sig_i,
  input  logic signed [UEW-1:0] uexp_i,
  output logic [INTW-1:0]       int_o,
  output logic                  guard_o,
  output logic                  sticky_o,
  output logic                  huge_o
);
  localparam logic signed [UEW-1:0] EXP_HI = UEW'(MODLIM);
  localparam logic signed [UEW-1:0] EXP_LO = UEW'(-1);

  logic           below;
  logic [SHW-1:0] shamt;
  logic [UEW-1:0] uexp_p1;
  logic [PW-1:0]  placed;

  assign huge_o  = uexp_i > EXP_HI;
  assign below   = uexp_i < EXP_LO;
  assign uexp_p1 = uexp_i + UEW'(1);
  assign shamt   = (huge_o | below) ? '0 : uexp_p1[SHW-1:0];
  assign placed  = PW'(sig_i) << shamt;

  always_comb begin
    if (below) begin
      int_o    = '0;
      guard_o  = 1'b0;
      sticky_o = |sig_i;
    end else begin
      int_o    = placed[PW-1 -: INTW];
      guard_o  = placed[FRACW];
      sticky_o = |placed[FRACW-1:0];
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INTW = 86,
  localparam int MAGW = INTW + 1
) (
  input  logic [INTW-1:0] int_i,
  input  logic            guard_i,
  input  logic            sticky_i,
  input  logic            neg_i,
  input  logic [2:0]      rm_i,
  output logic [MAGW-1:0] mag_o
);
  logic inexact, bump;

  assign inexact = guard_i | sticky_i;

  always_comb begin
    case (rmode_e'(rm_i))
      RM_NEAR_EVEN: bump = guard_i & (sticky_i | int_i[0]);
      RM_DOWN:      bump = neg_i & inexact;
      RM_UP:        bump = ~neg_i & inexact;
      RM_NEAR_AWAY: bump = guard_i;
      default:      bump = 1'b0;
    endcase
  end

  assign mag_o = {1'b0, int_i} + MAGW'(bump);
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv #(
  parameter int EXPW  = 11,
  parameter int FRACW = 52,
  parameter int OUTW  = 64,
  parameter int NARW  = 32,
  localparam int OPW    = EXPW + FRACW + 1,
  localparam int UEW    = EXPW + 2,
  localparam int MODLIM = NARW + FRACW,
  localparam int INTW   = MODLIM + 2,
  localparam int MAGW   = INTW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  op_i,
  input  logic [2:0]      rm_i,
  input  logic            signed_i,
  input  logic            wide_i,
  input  logic            modular_i,
  output logic [OUTW-1:0] res_o,
  output logic            invalid_o
);
  localparam logic [MAGW-1:0] ONE     = MAGW'(1);
  localparam logic [MAGW-1:0] LIM_SWP = (ONE << (OUTW - 1)) - ONE;
  localparam logic [MAGW-1:0] LIM_SWN = ONE << (OUTW - 1);
  localparam logic [MAGW-1:0] LIM_SNP = (ONE << (NARW - 1)) - ONE;
  localparam logic [MAGW-1:0] LIM_SNN = ONE << (NARW - 1);
  localparam logic [MAGW-1:0] LIM_UWP = (ONE << OUTW) - ONE;
  localparam logic [MAGW-1:0] LIM_UNP = (ONE << NARW) - ONE;

  logic                  sign, is_nan, is_inf, huge, guard, sticky;
  logic [FRACW:0]        sig;
  logic signed [UEW-1:0] uexp;
  logic [INTW-1:0]       int_part;
  logic [MAGW-1:0]       mag, lim;
  logic                  oor, neg_sat;
  logic [OUTW-1:0]       sval, sat, narrow_ext, res_d;
  logic                  inv_d;

  f2i_unpack #(.EXPW(EXPW), .FRACW(FRACW)) u_unpack (
    .op_i(op_i), .sign_o(sign), .nan_o(is_nan), .inf_o(is_inf),
    .sig_o(sig), .uexp_o(uexp)
  );

  f2i_align #(.EXPW(EXPW), .FRACW(FRACW), .NARW(NARW)) u_align (
    .sig_i(sig), .uexp_i(uexp), .int_o(int_part), .guard_o(guard),
    .sticky_o(sticky), .huge_o(huge)
  );

  f2i_round #(.INTW(INTW)) u_round (
    .int_i(int_part), .guard_i(guard), .sticky_i(sticky), .neg_i(sign),
    .rm_i(rm_i), .mag_o(mag)
  );

  // range limit on the rounded magnitude for the chosen destination
  always_comb begin
    if (modular_i)     lim = sign ? LIM_SNN : LIM_SNP;
    else if (signed_i) lim = wide_i ? (sign ? LIM_SWN : LIM_SWP)
                                    : (sign ? LIM_SNN : LIM_SNP);
    else if (sign)     lim = '0;
    else               lim = wide_i ? LIM_UWP : LIM_UNP;
  end
  assign oor = huge | (mag > lim);

  // saturation value; a NaN counts as positive
  assign neg_sat = sign & ~is_nan;
  always_comb begin
    if (signed_i) begin
      if (wide_i) sat = neg_sat ? {1'b1, {(OUTW-1){1'b0}}} : {1'b0, {(OUTW-1){1'b1}}};
      else        sat = neg_sat ? {{(OUTW-NARW+1){1'b1}}, {(NARW-1){1'b0}}}
                                : {{(OUTW-NARW+1){1'b0}}, {(NARW-1){1'b1}}};
    end else begin
      sat = neg_sat ? '0 : '1;
    end
  end

  assign sval       = sign ? -mag[OUTW-1:0] : mag[OUTW-1:0];
  assign narrow_ext = {{(OUTW-NARW){sval[NARW-1]}}, sval[NARW-1:0]};

  always_comb begin
    if (is_nan | is_inf) begin
      res_d = modular_i ? '0 : sat;
      inv_d = 1'b1;
    end else if (modular_i) begin
      res_d = huge ? '0 : narrow_ext;
      inv_d = oor;
    end else if (oor) begin
      res_d = sat;
      inv_d = 1'b1;
    end else begin
      res_d = wide_i ? sval : narrow_ext;
      inv_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int EXPW  = 11,
  parameter int FRACW = 52,
  parameter int OUTW  = 64,
  parameter int NARW  = 32,
  localparam int OPW  = EXPW + FRACW + 1
) (
  input logic            clk,
  input logic            rst,
  input logic [OPW-1:0]  op_i,
  input logic [2:0]      rm_i,
  input logic            signed_i,
  input logic            wide_i,
  input logic            modular_i,
  input logic [OUTW-1:0] res_o,
  input logic            invalid_o
);
  logic live = 1'b0;
  always_ff @(posedge clk) live <= ~rst;

  logic emax;
  assign emax = &op_i[OPW-2 -: EXPW];

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (res_o == '0) && !invalid_o);

  a_r6_special_invalid: assert property (@(posedge clk) disable iff (rst || !live)
    $past(emax) |-> invalid_o);

  a_r7_narrow_sext: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!wide_i || modular_i) |-> (res_o[OUTW-1:NARW] == {(OUTW-NARW){res_o[NARW-1]}}));

  a_r9_modular_special_zero: assert property (@(posedge clk) disable iff (rst || !live)
    $past(modular_i && emax) |-> (res_o == '0));

  a_r5_nan_positive: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!modular_i && emax && (|op_i[FRACW-1:0]) && signed_i && wide_i)
      |-> (res_o == {1'b0, {(OUTW-1){1'b1}}}));

  a_r4_neg_inf_signed: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!modular_i && emax && !(|op_i[FRACW-1:0]) && op_i[OPW-1] && signed_i && wide_i)
      |-> (res_o == {1'b1, {(OUTW-1){1'b0}}}));

  a_r11_unsigned_negative: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!modular_i && !signed_i && op_i[OPW-1] && !(emax && (|op_i[FRACW-1:0])))
      |-> (res_o == '0));

  a_r2_stable_without_edge: assert property (@(posedge clk) disable iff (rst || !live)
    $stable(op_i) && $stable(rm_i) && $stable({signed_i, wide_i, modular_i})
      && $past($stable(op_i)) |-> $stable(res_o));
endmodule

bind f2i_conv f2i_conv_chk #(.EXPW(EXPW), .FRACW(FRACW), .OUTW(OUTW), .NARW(NARW)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .rm_i(rm_i), .signed_i(signed_i),
  .wide_i(wide_i), .modular_i(modular_i), .res_o(res_o), .invalid_o(invalid_o)
);

// File: tb/f2i_conv_tb.sv
module f2i_conv_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_i = '0;
  logic [2:0]  rm_i = '0;
  logic        signed_i = 1'b0, wide_i = 1'b0, modular_i = 1'b0;
  logic [63:0] res_o;
  logic        invalid_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  f2i_conv u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .rm_i(rm_i), .signed_i(signed_i),
    .wide_i(wide_i), .modular_i(modular_i), .res_o(res_o), .invalid_o(invalid_o)
  );

  // {op, rm, signed, wide, modular, expected result, expected invalid}
  localparam int NV = 28;
  localparam logic [134:0] VEC [NV] = '{
    {64'h7FF0000000000000, 3'd0, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFFFFFFFFFF, 1'b1},
    {64'hFFF0000000000000, 3'd0, 1'b1, 1'b1, 1'b0, 64'h8000000000000000, 1'b1},
    {64'hFFF0000000000000, 3'd0, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFF80000000, 1'b1},
    {64'hFFF0000000000000, 3'd0, 1'b0, 1'b1, 1'b0, 64'h0000000000000000, 1'b1},
    {64'h7FF8000000000000, 3'd0, 1'b1, 1'b0, 1'b0, 64'h000000007FFFFFFF, 1'b1},
    {64'hFFF8000000000000, 3'd0, 1'b0, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1},
    {64'hFFF8000000000000, 3'd0, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1},
    {64'h43E0000000000000, 3'd1, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFFFFFFFFFF, 1'b1},
    {64'hC3E0000000000000, 3'd1, 1'b1, 1'b1, 1'b0, 64'h8000000000000000, 1'b0},
    {64'h43E0000000000000, 3'd1, 1'b0, 1'b1, 1'b0, 64'h8000000000000000, 1'b0},
    {64'h43F0000000000000, 3'd1, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1},
    {64'h43EFFFFFFFFFFFFF, 3'd1, 1'b0, 1'b1, 1'b0, 64'hFFFFFFFFFFFFF800, 1'b0},
    {64'h41E0000000000000, 3'd1, 1'b1, 1'b0, 1'b0, 64'h000000007FFFFFFF, 1'b1},
    {64'hC1E0000000000000, 3'd1, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFF80000000, 1'b0},
    {64'h41E0000000000000, 3'd1, 1'b0, 1'b0, 1'b0, 64'hFFFFFFFF80000000, 1'b0},
    {64'h41F0000000000000, 3'd1, 1'b0, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b1},
    {64'h8000000000000000, 3'd0, 1'b1, 1'b1, 1'b0, 64'h0000000000000000, 1'b0},
    {64'h0000000000000001, 3'd3, 1'b1, 1'b1, 1'b0, 64'h0000000000000001, 1'b0},
    {64'h8000000000000001, 3'd2, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0},
    {64'h8000000000000001, 3'd2, 1'b0, 1'b1, 1'b0, 64'h0000000000000000, 1'b1},
    {64'h8000000000000001, 3'd3, 1'b0, 1'b1, 1'b0, 64'h0000000000000000, 1'b0},
    {64'h0000000000000001, 3'd0, 1'b1, 1'b1, 1'b0, 64'h0000000000000000, 1'b0},
    {64'h4200000000380000, 3'd0, 1'b1, 1'b0, 1'b1, 64'h0000000000000007, 1'b1},
    {64'hC1F0000000300000, 3'd0, 1'b0, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFD, 1'b1},
    {64'h4520000000000001, 3'd0, 1'b1, 1'b0, 1'b1, 64'hFFFFFFFF80000000, 1'b1},
    {64'h4540000000000000, 3'd0, 1'b1, 1'b0, 1'b1, 64'h0000000000000000, 1'b1},
    {64'hFFF0000000000000, 3'd0, 1'b1, 1'b1, 1'b1, 64'h0000000000000000, 1'b1},
    {64'h7FF8000000000000, 3'd0, 1'b0, 1'b0, 1'b1, 64'h0000000000000000, 1'b1}
  };
  string vtag [NV] = '{"R5", "R4", "R4 R7", "R4", "R5", "R5 R7", "R5", "R5", "R4", "R6",
                       "R5", "R6", "R5", "R4", "R7", "R5", "R11", "R10", "R10", "R11",
                       "R11", "R10", "R8", "R8", "R8", "R9", "R9", "R9"};

  real vals [19] = '{0.5, 1.5, 2.5, -0.5, -1.5, -2.5, 0.75, -0.25, 3.0e9, -3.0e9,
                     5.0e9, -5.0e9, 123.4375, -7.5, 2147483647.5, -2147483648.5,
                     4294967295.5, 1.0e15 + 0.5, -1.0e12 - 0.75};

  task automatic check(input string tag, input logic [63:0] er, input logic ei);
    n_chk++;
    if (res_o !== er || invalid_o !== ei) begin
      n_bad++;
      $display("FAIL %s op=%h rm=%0d s=%0b w=%0b m=%0b: got %h/%0b expected %h/%0b",
               tag, op_i, rm_i, signed_i, wide_i, modular_i, res_o, invalid_o, er, ei);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic [2:0] rm,
                       input logic sg, input logic wd, input logic md);
    @(negedge clk);
    op_i = op; rm_i = rm; signed_i = sg; wide_i = wd; modular_i = md;
    @(posedge clk);
    #1;
  endtask

  // reference built from real arithmetic, for |r| < 2^50
  task automatic ref_conv(input real r, input logic [2:0] rm, input logic sg,
                          input logic wd, input logic md,
                          output logic [63:0] res, output logic inv);
    longint fl, ce, v;
    real fr;
    fl = longint'(r);
    if (real'(fl) > r) fl = fl - 1;
    fr = r - real'(fl);
    ce = (fr == 0.0) ? fl : fl + 1;
    case (rm)
      3'd0: v = (fr > 0.5) ? ce : (fr < 0.5) ? fl : (fl[0] ? ce : fl);
      3'd2: v = fl;
      3'd3: v = ce;
      3'd4: v = (fr > 0.5) ? ce : (fr < 0.5) ? fl : ((r < 0.0) ? fl : ce);
      default: v = (r < 0.0) ? ce : fl;
    endcase
    if (md)
      inv = (v < -64'sd2147483648) || (v > 64'sd2147483647);
    else if (sg)
      inv = !wd && ((v < -64'sd2147483648) || (v > 64'sd2147483647));
    else
      inv = (v < 0) || (!wd && v > 64'sd4294967295);
    if (md || !wd) res = {{32{v[31]}}, v[31:0]};
    else           res = v;
    if (inv && !md) begin
      if (sg) res = wd ? ((v < 0) ? 64'h8000000000000000 : 64'h7FFFFFFFFFFFFFFF)
                       : ((v < 0) ? 64'hFFFFFFFF80000000 : 64'h000000007FFFFFFF);
      else    res = (v < 0) ? 64'h0 : 64'hFFFFFFFFFFFFFFFF;
    end
  endtask

  initial begin
    logic [63:0] er;
    logic ei;
    // R1: reset clears the registers while the inputs ask for a saturation
    op_i = 64'h7FF0000000000000; signed_i = 1'b1; wide_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", 64'h0, 1'b0);
    @(negedge clk) rst = 1'b0;

    // R2: one-cycle latency, the old value holds until the edge
    apply(64'h3FF8000000000000, 3'd0, 1'b1, 1'b1, 1'b0);
    check("R2 R3", 64'd2, 1'b0);
    @(negedge clk);
    op_i = 64'hC004000000000000;
    #1 check("R2", 64'd2, 1'b0);
    @(posedge clk);
    #1 check("R2 R3", 64'hFFFFFFFFFFFFFFFE, 1'b0);

    // directed table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][134:71], VEC[i][70:68], VEC[i][67], VEC[i][66], VEC[i][65]);
      check(vtag[i], VEC[i][64:1], VEC[i][0]);
    end

    // every rounding code, signedness, width and mode against the real model
    for (int k = 0; k < 19; k++)
      for (int rm = 0; rm < 8; rm++)
        for (int c = 0; c < 8; c++) begin
          ref_conv(vals[k], 3'(rm), c[2], c[1], c[0], er, ei);
          apply($realtobits(vals[k]), 3'(rm), c[2], c[1], c[0]);
          check("R3 R6 R7 R8", er, ei);
        end

    // R1 again: reset in mid-run
    apply(64'h7FF0000000000000, 3'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 check("R1", 64'h0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule